// File: doc/BRIEF.md
# Buffered Serial Receiver with Break Detection

This block turns an asynchronous serial line into characters. It times each bit from a 16x bit-rate clock enable. The character length can be set from five to eight data bits, and an optional parity bit can be checked in one of several modes. Each finished character goes into a four-entry first-in first-out store together with its own status flags. A host takes characters from the head of that store through a one-cycle pop strobe.

A start edge that does not hold low until the middle of the bit is dropped, and the receiver goes back to hunting. A line held low through a whole character is stored as a break entry. If the line drops low partway through a character, that character is stored with a framing error and a break entry follows it. After a break, nothing new is assembled until the line returns high. A ready-to-send output falls while the store is full, so the far transmitter can hold off. If a character arrives while the store is full, it is thrown away and the newest stored entry is marked as overrun.

Top module: `serial_rx_buffered`

## Requirements
- R1: After reset `valid_o` is 0 and `rts_o` is 1.
- R2: `len_sel_i` sets the data length as 0→5, 1→6, 2→7 and 3→8 bits. Bits arrive LSB first. `data_o` holds the character zero-extended to 8 bits.
- R3: `par_sel_i` sets parity as 0 none, 1 even, 2 odd, 3 fixed. Fixed means the parity bit must equal `par_fix_i`. A parity bit that does not match sets `parity_err_o` on that entry.
- R4: A low level starts a character, and the line is sampled again 8 ticks later. If it is high then, no character is stored and hunting resumes.
- R5: A stop bit sampled low sets `frame_err_o` on that entry.
- R6: All-zero data, a zero parity bit (when parity is enabled) and a low stop bit give an entry with `data_o`=0, `break_o`=1 and `frame_err_o`=1. No further entry is made until the line has been high.
- R7: A break that begins partway through a character gives a framing-error entry with `break_o`=0, followed by a break entry.
- R8: The store holds four entries in arrival order. A `rd_i` pulse while `valid_o` is 1 removes the head and shows the next entry. `rd_i` while the store is empty has no effect.
- R9: A character that completes while four entries are held is discarded. The held entries keep their data, and only the newest one gets `overrun_o`=1.
- R10: `rts_o` is 0 exactly while four entries are held.
- R11: A character that completes in the same cycle as a pop of a full store is accepted, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 16x bit-rate enable |
| rxd_i | input | 1 | Serial line, idle high |
| len_sel_i | input | 2 | Data length select |
| par_sel_i | input | 2 | Parity mode select |
| par_fix_i | input | 1 | Expected bit in fixed parity mode |
| rd_i | input | 1 | Pop head entry |
| valid_o | output | 1 | Store not empty |
| data_o | output | 8 | Head character |
| parity_err_o | output | 1 | Head parity error |
| frame_err_o | output | 1 | Head framing error |
| break_o | output | 1 | Head is a break |
| overrun_o | output | 1 | A character was lost after the head |
| rts_o | output | 1 | Ready to receive; low while full |

## Verification
The two functions that can land in the same clock are the store of a finished character and a host pop of a full store. The bench fills all four entries first. It then sends a fifth character and raises `rd_i` in the exact cycle the stop-bit sample writes into the store. To find that cycle it counts the two synchroniser stages, the half-bit start check, the data and stop sampling, and the registered push. It then passes only if the four entries drained afterwards are characters two to five, in order, with no overrun flag. A separate run without the pop checks that the fifth character is lost and that only the fourth entry is marked.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FIXED = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
    logic              ovr;
  } rx_entry_t;
endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic [1:0] len_sel_i,
  input  par_mode_e par_sel_i,
  input  logic      par_fix_i,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  typedef enum logic [2:0] {S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_MARK} st_e;

  st_e              state_q;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       idx_q;
  logic [DATA_W-1:0] sh_q;
  logic             par_q;
  logic             rx_s;
  logic [DATA_W-1:0] data_al;
  logic             perr_c, brk_c, ones;

  assign rx_s    = sync_q[1];
  assign data_al = sh_q >> (2'd3 - len_sel_i);
  assign ones    = ^data_al;

  always_comb begin
    unique case (par_sel_i)
      PAR_EVEN:  perr_c = ones ^ par_q;
      PAR_ODD:   perr_c = ~(ones ^ par_q);
      PAR_FIXED: perr_c = par_q != par_fix_i;
      default:   perr_c = 1'b0;
    endcase
    brk_c = !rx_s && (data_al == '0) && (par_sel_i == PAR_NONE || !par_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HUNT;
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          S_HUNT: if (!rx_s) begin
            state_q <= S_START;
            cnt_q   <= '0;
          end
          S_START: if (cnt_q == MID) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rx_s ? S_HUNT : S_DATA;
          end else cnt_q <= cnt_q + 1'b1;
          S_DATA: if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
            if (idx_q == 3'd4 + {1'b0, len_sel_i})
              state_q <= (par_sel_i == PAR_NONE) ? S_STOP : S_PAR;
            else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
          S_PAR: if (cnt_q == LAST) begin
            cnt_q   <= '0;
            par_q   <= rx_s;
            state_q <= S_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          S_STOP: if (cnt_q == LAST) begin
            cnt_q   <= '0;
            push_o  <= 1'b1;
            entry_o <= '{data: data_al, perr: perr_c, ferr: !rx_s, brk: brk_c, ovr: 1'b0};
            state_q <= brk_c ? S_MARK : S_HUNT;
          end else cnt_q <= cnt_q + 1'b1;
          S_MARK: if (rx_s) state_q <= S_HUNT;
          default: state_q <= S_HUNT;
        endcase
      end
    end
  end

  // R4
  false_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == S_START && cnt_q == MID && rx_s) |=> state_q == S_HUNT);

  // R6
  mark_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && entry_o.brk) |=> (state_q == S_MARK || state_q == S_HUNT) && !push_o);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      valid_o,
  output logic      full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, newest;
  logic [CNT_W-1:0] count_q;
  logic             pop, accept;

  assign full_o  = count_q == CNT_FULL;
  assign valid_o = count_q != '0;
  assign pop     = pop_i && valid_o;
  assign accept  = push_i && (!full_o || pop);
  assign newest  = (wr_q == '0) ? PTR_MAX : wr_q - 1'b1;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (accept) begin
        mem_q[wr_q] <= entry_i;
        wr_q <= (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      end else if (push_i) begin
        mem_q[newest].ovr <= 1'b1;
      end
      if (pop) rd_q <= (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
      count_q <= count_q + CNT_W'(accept) - CNT_W'(pop);
    end
  end

  // R8
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_FULL);

  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !valid_o && !push_i) |=> !valid_o);

  // R9
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o && $stable(rd_q) && $stable(wr_q));

  // R11
  swap_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full_o) |=> full_o && !mem_q[newest].ovr);
endmodule

// File: rtl/serial_rx_buffered.sv
module serial_rx_buffered
  import rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_sel_i,
  input  logic       par_fix_i,
  input  logic       rd_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       parity_err_o,
  output logic       frame_err_o,
  output logic       break_o,
  output logic       overrun_o,
  output logic       rts_o
);
  rx_entry_t rx_entry, head;
  logic      rx_push, full;

  rx_deser #(.OSR(OSR)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rxd_i     (rxd_i),
    .len_sel_i (len_sel_i),
    .par_sel_i (par_mode_e'(par_sel_i)),
    .par_fix_i (par_fix_i),
    .push_o    (rx_push),
    .entry_o   (rx_entry)
  );

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .entry_i (rx_entry),
    .pop_i   (rd_i),
    .head_o  (head),
    .valid_o (valid_o),
    .full_o  (full)
  );

  assign data_o       = head.data;
  assign parity_err_o = head.perr;
  assign frame_err_o  = head.ferr;
  assign break_o      = head.brk;
  assign overrun_o    = head.ovr;
  assign rts_o        = !full;

  // R10
  rts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rts_o && !rd_i) |=> !rts_o);
endmodule

// File: tb/serial_rx_buffered_test.sv
`timescale 1ns/1ps
module serial_rx_buffered_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, rd = 1'b0;
  logic [1:0] len_sel = 2'd3, par_sel = 2'd0;
  logic par_fix = 1'b0;
  logic valid, perr, ferr, brk, ovr, rts;
  logic [7:0] data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_rx_buffered uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .rxd_i(rxd),
    .len_sel_i(len_sel), .par_sel_i(par_sel), .par_fix_i(par_fix), .rd_i(rd),
    .valid_o(valid), .data_o(data), .parity_err_o(perr), .frame_err_o(ferr),
    .break_o(brk), .overrun_o(ovr), .rts_o(rts)
  );

  // {len, par, fix, data, badpar, stop, exp_perr, exp_ferr}
  localparam logic [16:0] VEC [9] = '{
    {2'd3, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 1'b0, 8'hF3, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'd1, 1'b0, 8'h2A, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'd2, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd2, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd3, 2'd3, 1'b1, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd3, 1'b0, 8'h7E, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd3, 2'd1, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd3, 2'd1, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int bits);
    rxd = v;
    repeat (bits * 16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic badpar, input logic stop);
    int n = 5 + len_sel;
    logic [7:0] m = d & ((8'd1 << n) - 8'd1);
    logic p;
    hold(1'b0, 1);
    for (int i = 0; i < n; i++) hold(d[i], 1);
    if (par_sel != 2'd0) begin
      p = (par_sel == 2'd1) ? ^m : (par_sel == 2'd2) ? ~^m : par_fix;
      hold(p ^ badpar, 1);
    end
    hold(stop, 1);
    hold(1'b1, 2);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", valid, 0);
    chk("R1 rts", rts, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R5 vector walk
    foreach (VEC[k]) begin
      len_sel = VEC[k][16:15];
      par_sel = VEC[k][14:13];
      par_fix = VEC[k][12];
      send(VEC[k][11:4], VEC[k][3], VEC[k][2]);
      chk("R2 valid", valid, 1);
      chk("R2 data", data, VEC[k][11:4] & ((8'd1 << (5 + VEC[k][16:15])) - 8'd1));
      chk("R3 parity", perr, VEC[k][1]);
      chk("R5 frame", ferr, VEC[k][0]);
      chk("R6 no break", brk, 0);
      pop();
      chk("R8 drained", valid, 0);
    end
    len_sel = 2'd3; par_sel = 2'd0;

    // R8: pop on empty store
    pop();
    chk("R8 empty pop", valid, 0);

    // R4: false start
    hold(1'b0, 0); rxd = 1'b0; repeat (4) @(negedge clk);
    hold(1'b1, 3);
    chk("R4 false start", valid, 0);
    send(8'h6B, 0, 1);
    chk("R4 resumes", data, 8'h6B);
    pop();

    // R6: full break
    hold(1'b0, 12);
    chk("R6 valid", valid, 1);
    chk("R6 break", brk, 1);
    chk("R6 frame", ferr, 1);
    chk("R6 data", data, 0);
    pop();
    hold(1'b0, 12);
    chk("R6 no more while low", valid, 0);
    hold(1'b1, 2);
    send(8'h11, 0, 1);
    chk("R6 after mark", data, 8'h11);
    pop();

    // R7: break starting mid-character
    hold(1'b0, 1); hold(1'b1, 1); hold(1'b0, 1); hold(1'b1, 1);
    hold(1'b0, 25);
    chk("R7 first ferr", ferr, 1);
    chk("R7 first brk", brk, 0);
    chk("R7 first data", data, 8'h05);
    pop();
    chk("R7 second brk", brk, 1);
    pop();
    chk("R7 only two", valid, 0);
    hold(1'b1, 2);

    // R9 R10: overrun
    for (int i = 1; i <= 4; i++) begin
      chk("R10 rts before full", rts, 1);
      send(8'(8'h20 + i), 0, 1);
    end
    chk("R10 rts full", rts, 0);
    send(8'h99, 0, 1);
    for (int i = 1; i <= 4; i++) begin
      chk("R9 kept data", data, 8'(8'h20 + i));
      chk("R9 ovr flag", ovr, (i == 4));
      pop();
      chk("R10 rts after pop", rts, 1);
    end
    chk("R9 discarded", valid, 0);

    // R11: store and pop in the same cycle
    for (int i = 1; i <= 4; i++) send(8'(8'h40 + i), 0, 1);
    fork
      send(8'h45, 0, 1);
      begin
        repeat (155) @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
      end
    join
    chk("R11 still full", rts, 0);
    for (int i = 2; i <= 5; i++) begin
      chk("R11 order", data, 8'(8'h40 + i));
      chk("R11 no ovr", ovr, 0);
      pop();
    end
    chk("R11 drained", valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule